// File: doc/BRIEF.md
# Signed Adder/Subtractor with Overflow Detection

This block adds or subtracts two signed operands held in two's-complement form, using a single ripple-carry adder for both operations. Subtraction reuses the adder: the second operand is bit-inverted and a carry of 1 is injected at the least significant position, so the adder computes A plus the negation of B. The operand width is a parameter, 4 bits by default.

Two independent enables choose the operation, one for addition and one for subtraction. With neither enable raised the block is idle and drives zeros. With both raised the request is illegal: the block drives zeros and raises an error flag. Alongside the N-bit result it reports the raw carry out of the most significant bit, which is not part of the result, and a signed overflow flag. An optional output register, on by default, adds one clock of latency and is cleared by a synchronous active-high reset.

Top module: `signed_addsub`

## Requirements
- R1: With add_en=1 and sub_en=0, sum_out equals (a_in + b_in) modulo 2^WIDTH. Any carry beyond the top bit is dropped from the result.
- R2: With add_en=0 and sub_en=1, sum_out equals (a_in + (~b_in) + 1) modulo 2^WIDTH, which is the difference a_in - b_in. When a_in equals b_in the result is all zeros.
- R3: carry_out reports the carry leaving the most significant bit of the adder. For addition it is 1 when the unsigned sum a_in + b_in reaches 2^WIDTH. For subtraction it is 1 when the unsigned value of a_in is at least that of b_in.
- R4: ovf_out is 1 exactly when the true signed result lies outside the range -2^(WIDTH-1) to 2^(WIDTH-1)-1. It is never 1 when the two effective addends differ in sign, that is, in an addition whose operand sign bits differ or in a subtraction whose operand sign bits match.
- R5: Subtracting the most negative value (only the sign bit set) from zero sets ovf_out and returns the same most negative pattern.
- R6: With add_en=0 and sub_en=0, sum_out, carry_out, ovf_out and err_out are all 0.
- R7: With add_en=1 and sub_en=1, err_out is 1 and sum_out, carry_out and ovf_out are all 0.
- R8: With REGISTERED=1 (the default), every output reflects the inputs present at the previous rising clock edge. While rst is high at a rising edge, all outputs are cleared to 0.
- R9: err_out is 0 whenever exactly one of add_en and sub_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| add_en | input | 1 | Request addition |
| sub_en | input | 1 | Request subtraction |
| a_in | input | WIDTH | First operand, two's complement |
| b_in | input | WIDTH | Second operand (addend or subtrahend), two's complement |
| sum_out | output | WIDTH | Result, carry beyond the top bit dropped |
| carry_out | output | 1 | Raw carry out of the most significant bit |
| ovf_out | output | 1 | Signed overflow |
| err_out | output | 1 | Both enables raised together |

## Verification
With the default output register, every result and flag is due exactly one rising edge after its inputs are applied. The bench drives the inputs on a falling edge and compares the outputs on the next falling edge, which is half a period after the rising edge that captured them. A directed step confirms that the outputs still hold the previous result just before that capturing edge. The checker's clocked properties use a one-cycle implication for the same reason.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUB  = 2'b10,
        OP_BAD  = 2'b11
    } op_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic err;
    } flags_t;

    localparam flags_t FLAGS_CLEAR = '{carry: 1'b0, ovf: 1'b0, err: 1'b0};

    function automatic op_e classify(input logic add_req, input logic sub_req);
        op_e r;
        case ({sub_req, add_req})
            2'b01:   r = OP_ADD;
            2'b10:   r = OP_SUB;
            2'b11:   r = OP_BAD;
            default: r = OP_IDLE;
        endcase
        return r;
    endfunction

    // returns {carry, sum} of a one-bit full adder
    function automatic logic [1:0] full_add(input logic x, input logic y, input logic ci);
        logic s;
        logic co;
        s  = x ^ y ^ ci;
        co = (x & y) | (ci & (x ^ y));
        return {co, s};
    endfunction

endpackage

// File: rtl/addsub_decode.sv
module addsub_decode
    import addsub_pkg::*;
(
    input  logic add_en,
    input  logic sub_en,
    output op_e  op,
    output logic invert_b,
    output logic carry_in
);
    always_comb begin
        op       = classify(add_en, sub_en);
        invert_b = (op == OP_SUB);
        carry_in = (op == OP_SUB);
    end
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple
    import addsub_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             c_into_msb
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic [1:0] fa;
        assign fa         = full_add(x[i], y[i], chain[i]);
        assign sum[i]     = fa[0];
        assign chain[i+1] = fa[1];
    end

    assign cout       = chain[WIDTH];
    assign c_into_msb = chain[MSB];
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
    import addsub_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] raw_sum,
    input  logic             raw_cout,
    input  logic             raw_cmsb,
    output logic [WIDTH-1:0] result,
    output flags_t           flags
);
    always_comb begin
        result = '0;
        flags  = FLAGS_CLEAR;
        unique case (op)
            OP_ADD, OP_SUB: begin
                result      = raw_sum;
                flags.carry = raw_cout;
                flags.ovf   = raw_cout ^ raw_cmsb;
            end
            OP_BAD: flags.err = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/signed_addsub.sv
module signed_addsub
    import addsub_pkg::*;
#(
    parameter int WIDTH      = 4,
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             add_en,
    input  logic             sub_en,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             ovf_out,
    output logic             err_out
);
    op_e              op;
    logic             invert_b;
    logic             carry_in;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] raw_sum;
    logic             raw_cout;
    logic             raw_cmsb;
    logic [WIDTH-1:0] result_c;
    flags_t           flags_c;

    addsub_decode u_decode (
        .add_en   (add_en),
        .sub_en   (sub_en),
        .op       (op),
        .invert_b (invert_b),
        .carry_in (carry_in)
    );

    assign b_eff = b_in ^ {WIDTH{invert_b}};

    addsub_ripple #(.WIDTH(WIDTH)) u_adder (
        .x          (a_in),
        .y          (b_eff),
        .cin        (carry_in),
        .sum        (raw_sum),
        .cout       (raw_cout),
        .c_into_msb (raw_cmsb)
    );

    addsub_flags #(.WIDTH(WIDTH)) u_flags (
        .op       (op),
        .raw_sum  (raw_sum),
        .raw_cout (raw_cout),
        .raw_cmsb (raw_cmsb),
        .result   (result_c),
        .flags    (flags_c)
    );

    if (REGISTERED) begin : g_reg
        logic [WIDTH-1:0] sum_q;
        flags_t           flags_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                sum_q   <= '0;
                flags_q <= FLAGS_CLEAR;
            end else begin
                sum_q   <= result_c;
                flags_q <= flags_c;
            end
        end
        assign sum_out   = sum_q;
        assign carry_out = flags_q.carry;
        assign ovf_out   = flags_q.ovf;
        assign err_out   = flags_q.err;
    end else begin : g_comb
        assign sum_out   = result_c;
        assign carry_out = flags_c.carry;
        assign ovf_out   = flags_c.ovf;
        assign err_out   = flags_c.err;
    end
endmodule

// File: rtl/signed_addsub_checker.sv
module signed_addsub_checker #(
    parameter int WIDTH      = 4,
    parameter bit REGISTERED = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             add_en,
    input logic             sub_en,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out,
    input logic             ovf_out,
    input logic             err_out
);
    localparam int MSB = WIDTH - 1;
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    if (REGISTERED) begin : g_props
        // R7
        both_err_chk: assert property (@(posedge clk) disable iff (rst)
            (add_en && sub_en) |=> (err_out && sum_out == '0 && !carry_out && !ovf_out));
        // R6
        idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (!add_en && !sub_en) |=> (sum_out == '0 && !carry_out && !ovf_out && !err_out));
        // R9
        single_no_err_chk: assert property (@(posedge clk) disable iff (rst)
            (add_en ^ sub_en) |=> !err_out);
        // R4
        add_mixed_sign_chk: assert property (@(posedge clk) disable iff (rst)
            (add_en && !sub_en && (a_in[MSB] != b_in[MSB])) |=> !ovf_out);
        // R4
        sub_same_sign_chk: assert property (@(posedge clk) disable iff (rst)
            (!add_en && sub_en && (a_in[MSB] == b_in[MSB])) |=> !ovf_out);
        // R2
        self_diff_chk: assert property (@(posedge clk) disable iff (rst)
            (!add_en && sub_en && a_in == b_in) |=> (sum_out == '0 && carry_out));
        // R5
        neg_min_chk: assert property (@(posedge clk) disable iff (rst)
            (!add_en && sub_en && a_in == '0 && b_in == MOST_NEG) |=> (ovf_out && sum_out == MOST_NEG));
        // R8
        reset_clear_chk: assert property (@(posedge clk)
            rst |=> (sum_out == '0 && !carry_out && !ovf_out && !err_out));
    end
endmodule

bind signed_addsub signed_addsub_checker #(.WIDTH(WIDTH), .REGISTERED(REGISTERED)) chk_i (.*);

// File: tb/signed_addsub_tb_top.sv
module signed_addsub_tb_top;
    localparam int W    = 4;
    localparam int MOD  = 1 << W;
    localparam int SMAX = (1 << (W-1)) - 1;
    localparam int SMIN = -(1 << (W-1));

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         add_en = 1'b0;
    logic         sub_en = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] sum_out;
    logic         carry_out;
    logic         ovf_out;
    logic         err_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    signed_addsub dut_i (
        .clk(clk), .rst(rst), .add_en(add_en), .sub_en(sub_en),
        .a_in(a_in), .b_in(b_in), .sum_out(sum_out),
        .carry_out(carry_out), .ovf_out(ovf_out), .err_out(err_out)
    );

    function automatic int as_signed(input int u);
        return (u > SMAX) ? u - MOD : u;
    endfunction

    // expected {err, ovf, carry, sum}
    function automatic int expect_vec(input bit ad, input bit sb, input int ua, input int ub);
        int total, s, sum, cy, ov, er;
        sum = 0; cy = 0; ov = 0; er = 0;
        if (ad && sb) begin
            er = 1;
        end else if (ad) begin
            total = ua + ub;
            sum = total % MOD; cy = total / MOD;
            s = as_signed(ua) + as_signed(ub);
            ov = (s > SMAX || s < SMIN) ? 1 : 0;
        end else if (sb) begin
            total = ua + ((~ub) & (MOD-1)) + 1;
            sum = total % MOD; cy = total / MOD;
            s = as_signed(ua) - as_signed(ub);
            ov = (s > SMAX || s < SMIN) ? 1 : 0;
        end
        return (er << (W+2)) | (ov << (W+1)) | (cy << W) | sum;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h (add=%0b sub=%0b a=%0h b=%0h)",
                     req, got, exp, add_en, sub_en, a_in, b_in);
        end
    endtask

    function automatic int observed();
        return ({29'd0, err_out, ovf_out, carry_out} << W) | int'(sum_out);
    endfunction

    // drive on a falling edge, compare on the following falling edge
    task automatic run(input string req, input bit ad, input bit sb, input int ua, input int ub);
        @(negedge clk);
        add_en = ad; sub_en = sb; a_in = W'(ua); b_in = W'(ub);
        @(negedge clk);
        check(req, observed(), expect_vec(ad, sb, ua, ub));
    endtask

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed);
        // R8: reset clears outputs even with an active request
        add_en = 1'b1; a_in = 4'h7; b_in = 4'h7;
        repeat (3) @(negedge clk);
        check("R8 reset", observed(), 0);
        rst = 1'b0;

        // R1 R3 R4: every pair, addition
        for (int a = 0; a < MOD; a++)
            for (int b = 0; b < MOD; b++)
                run("R1/R3/R4 add", 1'b1, 1'b0, a, b);
        // R2 R3 R4: every pair, subtraction
        for (int a = 0; a < MOD; a++)
            for (int b = 0; b < MOD; b++)
                run("R2/R3/R4 sub", 1'b0, 1'b1, a, b);

        // R5 negate most negative
        run("R5 neg min", 1'b0, 1'b1, 0, 1 << (W-1));
        check("R5 ovf set", int'(ovf_out), 1);
        // R2 self difference
        run("R2 a-a", 1'b0, 1'b1, 5, 5);
        check("R2 zero", int'(sum_out), 0);
        // R6 idle
        run("R6 idle", 1'b0, 1'b0, 9, 3);
        // R7 both enables
        run("R7 both", 1'b1, 1'b1, 7, 7);
        check("R7 err", int'(err_out), 1);
        // R9 single enable clears err
        run("R9 add after bad", 1'b1, 1'b0, 2, 3);
        check("R9 no err", int'(err_out), 0);

        // R8 latency: output holds until the capturing edge
        @(negedge clk);
        add_en = 1'b0; sub_en = 1'b1; a_in = 4'h3; b_in = 4'h6;
        @(posedge clk);
        #1;
        check("R8 latency", observed(), expect_vec(1'b0, 1'b1, 3, 6));
        @(negedge clk);
        add_en = 1'b1; sub_en = 1'b0; a_in = 4'h1; b_in = 4'h1;
        #1;
        check("R8 hold", observed(), expect_vec(1'b0, 1'b1, 3, 6));

        // random mix including all control combinations
        for (int k = 0; k < 300; k++) begin
            int ctl;
            ctl = int'($urandom % 4);
            run("R1/R2/R6/R7/R9 random", ctl[0], ctl[1],
                int'($urandom % MOD), int'($urandom % MOD));
        end

        // R8 mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8 reset mid-run", observed(), 0);
        rst = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule